// File: doc/BRIEF.md
# Per-Instruction Stride Prefetch Candidate Generator

This block observes the stream of demand loads, each given as the program counter of the load instruction and the byte address it touched. It keeps a small direct-mapped table with one entry per instruction slot. Each entry records the last address that instruction touched, the difference to the address before that, and a saturating confidence count. When an instruction repeats the same non-zero stride often enough, the block walks ahead of the current demand address and produces line-aligned prefetch candidates. It produces at most four lines per load, and fewer when the throttle's depth limit is lower.

Every candidate is checked against a scoreboard of lines that are already outstanding before it goes into a small candidate queue. A downstream issuer reads the queue with a valid/ready handshake and reports each completed prefetch on the retire inputs, which frees its scoreboard slot. Load observation never stalls. A candidate that finds the queue or the scoreboard full is discarded. A pulse on the phase input forgets everything the table has learned, so patterns are re-learned after a workload change.

Top module: `stride_pf_detector`

## Requirements
- R1: After reset, `cand_valid` is low and no entry, scoreboard slot or queue slot is occupied.
- R2: A load's entry is chosen by `ld_pc[3:0]` and tagged with the remaining PC bits. The first load of an instruction claims the entry and the second records the stride. Each further load with the same non-zero stride raises confidence by one, up to a maximum of 3. Candidates are produced on the load that brings confidence to 2 and on every later load that repeats the stride.
- R3: For a triggering load at address A with stride s (two's complement, so it may be negative), the candidates are the lines holding A+k*s for k = 1..D in increasing k, each given with address bits [5:0] zero. D = min(4, `depth_limit`), and a depth of 0 produces nothing.
- R4: A load whose stride differs from the stored stride sets confidence to 0 and stores the new stride. Two further matching loads are then needed before candidates reappear.
- R5: A zero stride never raises confidence and never produces candidates.
- R6: Instructions that map to different entries train independently when their loads are interleaved. A load from a different PC that maps to the same entry replaces it, and the previous instruction must re-learn from scratch.
- R7: A candidate whose line is held in the scoreboard is not queued. Each queued line takes a scoreboard slot until `retire_valid` presents an address in the same line. After that, the line can be queued again.
- R8: The queue holds 8 candidates. A candidate produced while it is full is discarded without taking a scoreboard slot, and loads keep being accepted.
- R9: `phase_clear` invalidates every table entry and stops any candidate walk in progress. The next loads of any instruction are then treated as first sightings.
- R10: A candidate that falls in the same line as the triggering demand address is skipped.
- R11: Candidates leave the queue in the order they were produced. While `cand_valid` is high and `cand_ready` is low, `cand_addr` holds its value.
- R12: The scoreboard tracks 12 lines. A new candidate that finds all 12 slots in use is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | A demand load is observed this cycle |
| ld_pc | input | 32 | Program counter of the observed load |
| ld_addr | input | 32 | Byte address of the observed load |
| phase_clear | input | 1 | Forget all learned strides |
| depth_limit | input | 3 | Lookahead limit from the throttle |
| cand_valid | output | 1 | Queue head holds a candidate |
| cand_addr | output | 32 | Line-aligned candidate address |
| cand_ready | input | 1 | Consumer takes the head candidate |
| retire_valid | input | 1 | An outstanding prefetch has completed |
| retire_addr | input | 32 | Address of the completed prefetch |

## Verification
A wrong confidence or stride value shows at the ports as candidates that appear one matching load too early or too late, or that step by the wrong amount. It is visible about six cycles after the load that should or should not have triggered them. A scoreboard slot that is never freed shows as a line that is missing when it is re-requested after its retirement, and a slot that is lost makes the scoreboard-full drop happen sooner than twelve lines. Stale table state after a phase pulse shows as candidates on the first matching load, where four loads are needed.

// File: rtl/spf_pkg.sv
package spf_pkg;

  // How a table entry is rewritten when a load reaches it.
  typedef enum logic [1:0] {
    UPD_ALLOC   = 2'd0,  // tag miss or empty slot: claim it
    UPD_CONFIRM = 2'd1,  // same non-zero stride seen again
    UPD_RETRAIN = 2'd2   // stride changed or zero
  } upd_e;

endpackage

// File: rtl/spf_table.sv
module spf_table
  import spf_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 4,
  parameter int CONF_W  = 2,
  parameter int CONF_TH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_clr,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              trig,
  output logic [ADDR_W-1:0] trig_addr,
  output logic [ADDR_W-1:0] trig_stride
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = PC_W - IDX_W;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;
  localparam logic [CONF_W-1:0] CONF_ON  = CONF_TH[CONF_W-1:0];

  // Entry fields kept in separate arrays so each maps to a plain RAM.
  logic [TAG_W-1:0]  tag_mem    [ENTRIES];
  logic [ADDR_W-1:0] last_mem   [ENTRIES];
  logic [ADDR_W-1:0] stride_mem [ENTRIES];
  logic [CONF_W-1:0] conf_mem   [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  logic [IDX_W-1:0]  ld_idx;
  logic              s1_v;
  logic [IDX_W-1:0]  s1_idx;
  logic [TAG_W-1:0]  s1_tag;
  logic [ADDR_W-1:0] s1_addr;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_last, rd_stride;
  logic [CONF_W-1:0] rd_conf;

  // Forwarding of an entry written in the same cycle it was read.
  logic              fwd_v;
  logic [TAG_W-1:0]  fwd_tag;
  logic [ADDR_W-1:0] fwd_last, fwd_stride;
  logic [CONF_W-1:0] fwd_conf;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_stride;
  logic [CONF_W-1:0] wr_conf;

  logic              cur_vld;
  logic [TAG_W-1:0]  cur_tag;
  logic [ADDR_W-1:0] cur_last, cur_stride, delta;
  logic [CONF_W-1:0] cur_conf;
  upd_e              kind;

  assign ld_idx = ld_pc[IDX_W-1:0];
  assign wr_en  = s1_v && !phase_clr;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[s1_idx]    <= s1_tag;
      last_mem[s1_idx]   <= s1_addr;
      stride_mem[s1_idx] <= wr_stride;
      conf_mem[s1_idx]   <= wr_conf;
    end
    if (ld_valid) begin
      rd_tag    <= tag_mem[ld_idx];
      rd_last   <= last_mem[ld_idx];
      rd_stride <= stride_mem[ld_idx];
      rd_conf   <= conf_mem[ld_idx];
    end
  end

  always_ff @(posedge clk) begin
    s1_idx     <= ld_idx;
    s1_tag     <= ld_pc[PC_W-1:IDX_W];
    s1_addr    <= ld_addr;
    fwd_tag    <= s1_tag;
    fwd_last   <= s1_addr;
    fwd_stride <= wr_stride;
    fwd_conf   <= wr_conf;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v  <= 1'b0;
      fwd_v <= 1'b0;
      vld_q <= '0;
    end else begin
      s1_v  <= ld_valid;
      fwd_v <= ld_valid && wr_en && (ld_idx == s1_idx);
      if (phase_clr)  vld_q         <= '0;
      else if (wr_en) vld_q[s1_idx] <= 1'b1;
    end
  end

  always_comb begin
    cur_vld    = fwd_v || vld_q[s1_idx];
    cur_tag    = fwd_v ? fwd_tag    : rd_tag;
    cur_last   = fwd_v ? fwd_last   : rd_last;
    cur_stride = fwd_v ? fwd_stride : rd_stride;
    cur_conf   = fwd_v ? fwd_conf   : rd_conf;
    delta      = s1_addr - cur_last;

    if (!(cur_vld && cur_tag == s1_tag))              kind = UPD_ALLOC;
    else if (delta == cur_stride && delta != '0)      kind = UPD_CONFIRM;
    else                                              kind = UPD_RETRAIN;

    unique case (kind)
      UPD_ALLOC: begin
        wr_stride = '0;
        wr_conf   = '0;
      end
      UPD_CONFIRM: begin
        wr_stride = delta;
        wr_conf   = (cur_conf == CONF_MAX) ? CONF_MAX : cur_conf + 1'b1;
      end
      default: begin
        wr_stride = delta;
        wr_conf   = '0;
      end
    endcase
  end

  assign trig        = wr_en && (kind == UPD_CONFIRM) && (wr_conf >= CONF_ON);
  assign trig_addr   = s1_addr;
  assign trig_stride = delta;

endmodule

// File: rtl/spf_walker.sv
module spf_walker #(
  parameter int ADDR_W    = 32,
  parameter int LINE_OFF  = 6,
  parameter int MAX_AHEAD = 4,
  parameter int LIM_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 phase_clr,
  input  logic                 trig,
  input  logic [ADDR_W-1:0]    trig_addr,
  input  logic [ADDR_W-1:0]    trig_stride,
  input  logic [LIM_W-1:0]     depth_lim,
  input  logic                 sb_hit,
  input  logic                 sb_full,
  input  logic                 q_full,
  output logic [ADDR_W-LINE_OFF-1:0] look_line,
  output logic                 push,
  output logic                 busy
);
  localparam int LINE_W = ADDR_W - LINE_OFF;
  localparam int CNT_W  = $clog2(MAX_AHEAD + 1);
  localparam logic [LIM_W-1:0] MAX_L = LIM_W'(MAX_AHEAD);

  logic              act_q;
  logic [ADDR_W-1:0] cur_q, stride_q, nxt;
  logic [LINE_W-1:0] dem_line_q;
  logic [CNT_W-1:0]  left_q, eff;
  logic [LIM_W-1:0]  eff_l;

  assign eff_l = (depth_lim > MAX_L) ? MAX_L : depth_lim;
  assign eff   = CNT_W'(eff_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
    end else if (phase_clr) begin
      act_q <= 1'b0;
    end else if (trig) begin
      act_q <= (eff != '0);
    end else if (act_q && left_q == CNT_W'(1)) begin
      act_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (trig) begin
      cur_q      <= trig_addr;
      stride_q   <= trig_stride;
      left_q     <= eff;
      dem_line_q <= trig_addr[ADDR_W-1:LINE_OFF];
    end else if (act_q) begin
      cur_q  <= nxt;
      left_q <= left_q - 1'b1;
    end
  end

  assign nxt       = cur_q + stride_q;
  assign look_line = nxt[ADDR_W-1:LINE_OFF];
  assign push      = act_q && (look_line != dem_line_q) && !sb_hit && !sb_full && !q_full;
  assign busy      = act_q;

endmodule

// File: rtl/spf_scoreboard.sv
module spf_scoreboard #(
  parameter int LINE_W = 26,
  parameter int SB_N   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] look_line,
  input  logic              alloc,
  input  logic              ret_v,
  input  logic [LINE_W-1:0] ret_line,
  output logic              hit,
  output logic              full,
  output logic [SB_N-1:0]   vld
);
  logic [SB_N-1:0]   vld_q, hit_v, ret_v_oh, alloc_oh;
  logic [LINE_W-1:0] line_q [SB_N];
  logic              found;

  for (genvar g = 0; g < SB_N; g++) begin : g_slot
    assign hit_v[g]    = vld_q[g] && (line_q[g] == look_line);
    assign ret_v_oh[g] = ret_v && vld_q[g] && (line_q[g] == ret_line);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[g] <= 1'b0;
      end else if (ret_v_oh[g]) begin
        vld_q[g] <= 1'b0;
      end else if (alloc && alloc_oh[g]) begin
        vld_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc && alloc_oh[g]) line_q[g] <= look_line;
    end
  end

  always_comb begin
    alloc_oh = '0;
    found    = 1'b0;
    for (int i = 0; i < SB_N; i++) begin
      if (!vld_q[i] && !found) begin
        alloc_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign hit  = |hit_v;
  assign full = &vld_q;
  assign vld  = vld_q;

endmodule

// File: rtl/spf_fifo.sv
module spf_fifo #(
  parameter int W     = 26,
  parameter int DEPTH = 8   // power of two
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         not_empty,
  output logic         full,
  output logic [W-1:0] head
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] CNT_FULL = (PTR_W+1)'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [PTR_W:0]   cnt;
  logic             do_push, do_pop;

  assign full      = (cnt == CNT_FULL);
  assign not_empty = (cnt != '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && not_empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign head = mem[rd_ptr];

endmodule

// File: rtl/stride_pf_detector.sv
module stride_pf_detector #(
  parameter int PC_W      = 32,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 4,
  parameter int LINE_OFF  = 6,
  parameter int CONF_W    = 2,
  parameter int CONF_TH   = 2,
  parameter int MAX_AHEAD = 4,
  parameter int LIM_W     = 3,
  parameter int Q_DEPTH   = 8,
  parameter int SB_N      = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  input  logic [PC_W-1:0]   ld_pc,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              phase_clear,
  input  logic [LIM_W-1:0]  depth_limit,
  output logic              cand_valid,
  output logic [ADDR_W-1:0] cand_addr,
  input  logic              cand_ready,
  input  logic              retire_valid,
  input  logic [ADDR_W-1:0] retire_addr
);
  localparam int LINE_W = ADDR_W - LINE_OFF;

  logic              trig;
  logic [ADDR_W-1:0] trig_addr, trig_stride;
  logic [LINE_W-1:0] look_line, head_line;
  logic              q_push, q_full, sb_hit, sb_full, gen_busy;
  logic [SB_N-1:0]   sb_vld;

  spf_table #(
    .PC_W(PC_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
    .CONF_W(CONF_W), .CONF_TH(CONF_TH)
  ) u_table (
    .clk(clk), .rst(rst), .phase_clr(phase_clear),
    .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_addr(ld_addr),
    .trig(trig), .trig_addr(trig_addr), .trig_stride(trig_stride)
  );

  spf_walker #(
    .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF),
    .MAX_AHEAD(MAX_AHEAD), .LIM_W(LIM_W)
  ) u_walker (
    .clk(clk), .rst(rst), .phase_clr(phase_clear),
    .trig(trig), .trig_addr(trig_addr), .trig_stride(trig_stride),
    .depth_lim(depth_limit), .sb_hit(sb_hit), .sb_full(sb_full),
    .q_full(q_full), .look_line(look_line), .push(q_push), .busy(gen_busy)
  );

  spf_scoreboard #(.LINE_W(LINE_W), .SB_N(SB_N)) u_sb (
    .clk(clk), .rst(rst), .look_line(look_line), .alloc(q_push),
    .ret_v(retire_valid), .ret_line(retire_addr[ADDR_W-1:LINE_OFF]),
    .hit(sb_hit), .full(sb_full), .vld(sb_vld)
  );

  spf_fifo #(.W(LINE_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst(rst), .push(q_push), .push_data(look_line),
    .pop(cand_ready), .not_empty(cand_valid), .full(q_full), .head(head_line)
  );

  assign cand_addr = {head_line, {LINE_OFF{1'b0}}};

endmodule

// File: rtl/spf_checks.sv
module spf_checks #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 6,
  parameter int SB_N     = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              phase_clear,
  input logic              cand_valid,
  input logic              cand_ready,
  input logic [ADDR_W-1:0] cand_addr,
  input logic              retire_valid,
  input logic              q_push,
  input logic              q_full,
  input logic              gen_busy,
  input logic [SB_N-1:0]   sb_vld
);

  a_r11_head_holds: assert property (@(posedge clk) disable iff (rst)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_addr));

  a_r3_line_aligned: assert property (@(posedge clk) disable iff (rst)
    cand_valid |-> cand_addr[LINE_OFF-1:0] == '0);

  a_r9_phase_stops_walk: assert property (@(posedge clk) disable iff (rst)
    phase_clear |=> !gen_busy);

  a_r8_full_persists: assert property (@(posedge clk) disable iff (rst)
    q_full && !(cand_valid && cand_ready) |=> q_full);

  a_r7_push_tracked: assert property (@(posedge clk) disable iff (rst)
    q_push && !retire_valid |=> $countones(sb_vld) == $past($countones(sb_vld)) + 1);

  a_r12_no_push_when_tracked_full: assert property (@(posedge clk) disable iff (rst)
    $countones(sb_vld) == SB_N |-> !q_push);

endmodule

bind stride_pf_detector spf_checks #(
  .ADDR_W(ADDR_W), .LINE_OFF(LINE_OFF), .SB_N(SB_N)
) u_chk (
  .clk(clk), .rst(rst), .phase_clear(phase_clear),
  .cand_valid(cand_valid), .cand_ready(cand_ready), .cand_addr(cand_addr),
  .retire_valid(retire_valid), .q_push(q_push), .q_full(q_full),
  .gen_busy(gen_busy), .sb_vld(sb_vld)
);

// File: tb/stride_pf_detector_tb.sv
module stride_pf_detector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_pc = '0;
  logic [31:0] ld_addr = '0;
  logic        phase_clear = 1'b0;
  logic [2:0]  depth_limit = 3'd7;
  logic        cand_valid;
  logic [31:0] cand_addr;
  logic        cand_ready = 1'b0;
  logic        retire_valid = 1'b0;
  logic [31:0] retire_addr = '0;

  int errors = 0;
  int checks = 0;
  logic [31:0] got [16];
  int got_n = 0;

  always #5 clk = ~clk;

  stride_pf_detector u_dut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_pc(ld_pc), .ld_addr(ld_addr),
    .phase_clear(phase_clear), .depth_limit(depth_limit),
    .cand_valid(cand_valid), .cand_addr(cand_addr), .cand_ready(cand_ready),
    .retire_valid(retire_valid), .retire_addr(retire_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] pc, input logic [31:0] a);
    @(negedge clk);
    ld_valid = 1'b1; ld_pc = pc; ld_addr = a;
    @(negedge clk);
    ld_valid = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic do_retire(input logic [31:0] a);
    @(negedge clk);
    retire_valid = 1'b1; retire_addr = a;
    @(negedge clk);
    retire_valid = 1'b0;
  endtask

  task automatic drain(input bit ret);
    got_n = 0;
    @(negedge clk);
    while (cand_valid && got_n < 16) begin
      got[got_n] = cand_addr;
      got_n++;
      cand_ready = 1'b1;
      retire_valid = ret;
      retire_addr = cand_addr;
      @(negedge clk);
      cand_ready = 1'b0;
      retire_valid = 1'b0;
    end
  endtask

  task automatic expect_seq(input string req, input int n,
                            input logic [31:0] first, input logic [31:0] step);
    chk(got_n == n, req, "candidate count", 32'(got_n), 32'(n));
    for (int i = 0; i < n && i < got_n; i++)
      chk(got[i] == first + 32'(i) * step, req, $sformatf("candidate %0d", i),
          got[i], first + 32'(i) * step);
  endtask

  task automatic t_reset();
    chk(cand_valid == 1'b0, "R1", "cand_valid after reset", 32'(cand_valid), 0);
    drain(1'b0);
    chk(got_n == 0, "R1", "queue empty after reset", 32'(got_n), 0);
  endtask

  task automatic t_train_and_depth();
    logic [31:0] pc = 32'h0000_4000;
    logic [31:0] held;
    do_load(pc, 32'h1000);
    chk(!cand_valid, "R2", "none after 1st load", 32'(cand_valid), 0);
    do_load(pc, 32'h1040);
    chk(!cand_valid, "R2", "none after 2nd load", 32'(cand_valid), 0);
    do_load(pc, 32'h1080);
    chk(!cand_valid, "R2", "none after 3rd load", 32'(cand_valid), 0);
    do_load(pc, 32'h10C0);
    held = cand_addr;
    repeat (3) @(negedge clk);
    chk(cand_valid && cand_addr == held, "R11", "head holds while not ready", cand_addr, held);
    drain(1'b0);
    expect_seq("R3", 4, 32'h1100, 32'h40);
    do_load(pc, 32'h1100);
    drain(1'b1);
    expect_seq("R7", 1, 32'h1200, 32'h40);
    for (int i = 0; i < 4; i++) do_retire(32'h1100 + 32'(i) * 32'h40);
    depth_limit = 3'd2;
    do_load(pc, 32'h1140);
    drain(1'b1);
    expect_seq("R3", 2, 32'h1180, 32'h40);
    depth_limit = 3'd0;
    do_load(pc, 32'h1180);
    drain(1'b1);
    expect_seq("R3", 0, 32'h0, 32'h0);
    depth_limit = 3'd7;
    do_load(pc, 32'h11C0);
    drain(1'b1);
    expect_seq("R7", 4, 32'h1200, 32'h40);
  endtask

  task automatic t_mismatch();
    logic [31:0] pc = 32'h0000_4001;
    do_load(pc, 32'h2000); do_load(pc, 32'h2080);
    do_load(pc, 32'h2100); do_load(pc, 32'h2180);
    drain(1'b1);
    expect_seq("R4", 4, 32'h2200, 32'h80);
    do_load(pc, 32'h2190);
    do_load(pc, 32'h21A0);
    drain(1'b1);
    expect_seq("R4", 0, 32'h0, 32'h0);
    do_load(pc, 32'h21B0);
    drain(1'b1);
    expect_seq("R4", 1, 32'h21C0, 32'h0);
  endtask

  task automatic t_demand_line();
    logic [31:0] pc = 32'h0000_4002;
    do_load(pc, 32'h3000); do_load(pc, 32'h3008);
    do_load(pc, 32'h3010); do_load(pc, 32'h3018);
    drain(1'b1);
    expect_seq("R10", 0, 32'h0, 32'h0);
    do_load(pc, 32'h3020);
    drain(1'b1);
    expect_seq("R10", 1, 32'h3040, 32'h0);
  endtask

  task automatic t_negative();
    logic [31:0] pc = 32'h0000_4003;
    do_load(pc, 32'h5100); do_load(pc, 32'h50C0);
    do_load(pc, 32'h5080); do_load(pc, 32'h5040);
    drain(1'b1);
    expect_seq("R3", 4, 32'h5000, 32'hFFFF_FFC0);
  endtask

  task automatic t_zero_stride();
    for (int i = 0; i < 5; i++) do_load(32'h0000_4009, 32'h7000);
    drain(1'b1);
    expect_seq("R5", 0, 32'h0, 32'h0);
  endtask

  task automatic t_per_pc();
    logic [31:0] pa = 32'h0000_4004;
    logic [31:0] pb = 32'h0000_4005;
    for (int i = 0; i < 3; i++) begin
      do_load(pa, 32'h6000 + 32'(i) * 32'h40);
      do_load(pb, 32'h8000 + 32'(i) * 32'h100);
    end
    chk(!cand_valid, "R6", "interleaved training quiet", 32'(cand_valid), 0);
    do_load(pa, 32'h60C0);
    drain(1'b1);
    expect_seq("R6", 4, 32'h6100, 32'h40);
    do_load(pb, 32'h8300);
    drain(1'b1);
    expect_seq("R6", 4, 32'h8400, 32'h100);
    do_load(pa + 32'h10, 32'h6F00);
    do_load(pa, 32'h6100); do_load(pa, 32'h6140); do_load(pa, 32'h6180);
    drain(1'b1);
    expect_seq("R6", 0, 32'h0, 32'h0);
  endtask

  task automatic t_queue_full();
    logic [31:0] pc = 32'h0000_4006;
    for (int i = 0; i < 8; i++) do_load(pc, 32'h9000 + 32'(i) * 32'h40);
    do_load(pc, 32'h9200);
    drain(1'b1);
    expect_seq("R8", 8, 32'h9100, 32'h40);
    chk(!cand_valid, "R8", "overflow candidate discarded", 32'(cand_valid), 0);
    do_load(pc, 32'h9240);
    drain(1'b1);
    expect_seq("R8", 4, 32'h9280, 32'h40);
  endtask

  task automatic t_sb_full();
    logic [31:0] pc = 32'h0000_4007;
    int total = 0;
    for (int i = 0; i < 12; i++) begin
      do_load(pc, 32'hA000 + 32'(i) * 32'h40);
      drain(1'b0);
      total += got_n;
    end
    chk(total == 12, "R12", "lines tracked", 32'(total), 12);
    do_load(pc, 32'hA300);
    drain(1'b0);
    expect_seq("R12", 0, 32'h0, 32'h0);
    do_retire(32'hA100);
    do_load(pc, 32'hA340);
    drain(1'b0);
    expect_seq("R12", 1, 32'hA400, 32'h0);
    for (int i = 0; i < 12; i++) do_retire(32'hA140 + 32'(i) * 32'h40);
  endtask

  task automatic t_phase();
    logic [31:0] pc = 32'h0000_4008;
    for (int i = 0; i < 4; i++) do_load(pc, 32'hB000 + 32'(i) * 32'h40);
    drain(1'b1);
    expect_seq("R9", 4, 32'hB100, 32'h40);
    @(negedge clk); phase_clear = 1'b1;
    @(negedge clk); phase_clear = 1'b0;
    for (int i = 4; i < 7; i++) do_load(pc, 32'hB000 + 32'(i) * 32'h40);
    drain(1'b1);
    expect_seq("R9", 0, 32'h0, 32'h0);
    do_load(pc, 32'hB1C0);
    drain(1'b1);
    expect_seq("R9", 4, 32'hB200, 32'h40);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_train_and_depth();
    t_mismatch();
    t_demand_line();
    t_negative();
    t_zero_stride();
    t_per_pc();
    t_queue_full();
    t_sb_full();
    t_phase();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule